// File: doc/BRIEF.md
# Audio Port Sample Buffer

This block is the register-side data path of an I2S-style audio port. It sits between a byte-wide CPU/DMA register bus and a serializer/deserializer core. On the transmit side, software writes a sample as a low byte followed by a high byte. The high byte write commits the word into a one-entry TX buffer, and the serializer takes it from there. On the receive side, each deserialized sample lands in a one-entry RX buffer. Software reads it back as a low and a high byte, and the high byte read marks the word as consumed.

Transmit complete and receive complete events set sticky interrupt flags and fire one-cycle DMA trigger pulses. An underflow (a fetch from an empty TX buffer) replays the stale word. An overflow (a delivery into a full RX buffer) replaces the held word. A status register reports the flags and the left/right channel bits. Software may write that register to clear flags or to set them. Serial framing, clock generation and companding arithmetic are outside this block.

The serializer streams use valid/ready, but neither side can stall.
- **TX stream:** `tx_ready` is a fetch strobe that the serializer may raise at any time. `tx_valid` only reports whether the word offered is fresh.
- **RX stream:** `rx_valid` is a delivery strobe that is always accepted. `rx_ready` only reports that the buffer is empty.

Top module: `aud_xfer_buf`

## Requirements
- R1: After reset the following hold:
  - all flags, both buffers, the low-byte stage and both channel bits are 0;
  - `tx_valid` is 0 and `rx_ready` is 1;
  - `irq`, `dma_tx` and `dma_rx` are 0.
- R2: With `cfg_wide`=1 and `cfg_ulaw_exp`=0, a bus write to address 1 commits {written byte, last byte written to address 0} as the 16-bit TX word. The low byte is kept between words. `tx_data` shows the word and `tx_valid` is 1 from the next cycle.
- R3: With `cfg_wide`=0 or `cfg_ulaw_exp`=1, a write to address 1 alone commits {8'h00, written byte}.
- R4: Reads of the RX word work as follows:
  - address 0 reads bits 7:0;
  - address 1 reads bits 15:8 when `cfg_wide`=1 and `cfg_ulaw_cmp`=0, and bits 7:0 otherwise;
  - a read of address 1 empties the buffer (`rx_ready` back to 1) and clears the RX interrupt flag.
- R5: A `tx_ready` strobe while `tx_valid`=0 leaves `tx_data` unchanged (the stale word is sent again) and sets the TX underflow flag.
- R6: An `rx_valid` strobe while the RX buffer is full, with no address 1 read in the same cycle, replaces the buffered word and sets the RX overflow flag.
- R7: A write to address 2 loads its bits 3:0 into the flags. Underflow and overflow flags are otherwise changed only by their setting events, so data accesses leave them set.
- R8: `irq` = `glb_ien` & ((`tx_ien` & TX interrupt flag) | (`rx_ien` & RX interrupt flag)). This includes flags set by software.
- R9: Completion events behave as follows, whatever the enables:
  - each `tx_ready` strobe sets the TX interrupt flag and gives a one-cycle `dma_tx` pulse in the next cycle;
  - each `rx_valid` strobe does the same for the RX interrupt flag and `dma_rx`;
  - a write to address 1 clears the TX interrupt flag, unless a fetch happens in the same cycle.
- R10: The channel bits follow these rules:
  - in TX stereo, the TX channel bit (0 = left next) starts at 0 and toggles at each committed word;
  - the RX channel bit holds the `rx_right` tag of the last delivered word;
  - when the matching mono input is 1, the bit is 0.
- R11: Address 2 reads as follows:
  - bit 0 TX irq, bit 1 RX irq, bit 2 underflow, bit 3 overflow, bit 4 TX channel, bit 5 RX channel, other bits 0;
  - address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | Samples wider than 8 bits |
| cfg_ulaw_exp | input | 1 | TX companded mode: single-byte words |
| cfg_ulaw_cmp | input | 1 | RX companded mode: single-byte words |
| cfg_tx_mono | input | 1 | TX mono, channel bit held at 0 |
| cfg_rx_mono | input | 1 | RX mono, channel bit held at 0 |
| tx_ien | input | 1 | TX interrupt enable |
| rx_ien | input | 1 | RX interrupt enable |
| glb_ien | input | 1 | Global enable for this interrupt source |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tx_ready | input | 1 | Serializer fetch strobe |
| tx_valid | output | 1 | TX buffer holds a fresh word |
| tx_data | output | 16 | TX buffer contents |
| rx_valid | input | 1 | Deserializer delivery strobe |
| rx_ready | output | 1 | RX buffer empty |
| rx_data | input | 16 | Delivered sample |
| rx_right | input | 1 | Delivered sample is the right channel |
| irq | output | 1 | Interrupt request |
| dma_tx | output | 1 | TX-complete DMA trigger pulse |
| dma_rx | output | 1 | RX-complete DMA trigger pulse |

## Verification
The bench fetches twice with no new word in between. A design that cleared or altered the buffer on underflow would change `tx_data`, and one that missed the flag would leave status bit 2 low. It delivers two samples back to back. A design that dropped the late sample instead of overwriting would read back the first byte, and one that cleared overflow on the high-byte read would lose bit 3.

It also sweeps the width, companding and mono inputs. A mix-up of the narrow byte position, or a channel bit that kept toggling in mono, shows in the data or status reads. It changes the enables one at a time, so DMA pulses that were gated by the interrupt enables, or an `irq` that ignored the global enable, stand out.

// File: rtl/aud_xfer_pkg.sv
`timescale 1ns/1ps
package aud_xfer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] A_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam int ST_TXIRQ = 0;
  localparam int ST_RXIRQ = 1;
  localparam int ST_TXUNF = 2;
  localparam int ST_RXOVF = 3;
  localparam int ST_TXCH  = 4;
  localparam int ST_RXCH  = 5;
endpackage

// File: rtl/aud_xfer_tx.sv
`timescale 1ns/1ps
module aud_xfer_tx #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              narrow,
  input  logic              mono,
  input  logic              fetch,
  input  logic              sw_wr,
  input  logic              sw_irq,
  input  logic              sw_unf,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              irq_o,
  output logic              unf_o,
  output logic              chan_o,
  output logic              dma_o
);
  logic [BYTE_W-1:0] lo_q;
  logic [WORD_W-1:0] buf_q;
  logic              valid_q, irq_q, unf_q, chan_q, dma_q;
  logic [WORD_W-1:0] commit_word;

  always_comb begin
    if (narrow) commit_word = {{BYTE_W{1'b0}}, wdata};
    else        commit_word = {wdata, lo_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      buf_q   <= '0;
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
      unf_q   <= 1'b0;
      chan_q  <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      dma_q <= fetch;
      if (lo_wr) lo_q <= wdata;
      if (hi_wr) buf_q <= commit_word;
      if (hi_wr)      valid_q <= 1'b1;
      else if (fetch) valid_q <= 1'b0;
      if (fetch && !valid_q) unf_q <= 1'b1;
      else if (sw_wr)        unf_q <= sw_unf;
      if (fetch)      irq_q <= 1'b1;
      else if (sw_wr) irq_q <= sw_irq;
      else if (hi_wr) irq_q <= 1'b0;
      if (mono)       chan_q <= 1'b0;
      else if (hi_wr) chan_q <= ~chan_q;
    end
  end

  assign word_o  = buf_q;
  assign valid_o = valid_q;
  assign irq_o   = irq_q;
  assign unf_o   = unf_q;
  assign chan_o  = chan_q;
  assign dma_o   = dma_q;

  // R5
  tx_unf_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !valid_q && !hi_wr) |=> (unf_q && $stable(buf_q)));
  // R2
  tx_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> valid_q);
  // R9
  tx_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> (irq_q && dma_q));
  // R10
  tx_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mono |=> !chan_q);
endmodule

// File: rtl/aud_xfer_rx.sv
`timescale 1ns/1ps
module aud_xfer_rx #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deliver,
  input  logic [WORD_W-1:0] word_i,
  input  logic              right_i,
  input  logic              consume,
  input  logic              mono,
  input  logic              sw_wr,
  input  logic              sw_irq,
  input  logic              sw_ovf,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              chan_o,
  output logic              dma_o
);
  logic [WORD_W-1:0] buf_q;
  logic              valid_q, irq_q, ovf_q, chan_q, dma_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
      ovf_q   <= 1'b0;
      chan_q  <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      dma_q <= deliver;
      if (deliver) buf_q <= word_i;
      if (deliver)      valid_q <= 1'b1;
      else if (consume) valid_q <= 1'b0;
      if (deliver && valid_q && !consume) ovf_q <= 1'b1;
      else if (sw_wr)                     ovf_q <= sw_ovf;
      if (deliver)      irq_q <= 1'b1;
      else if (sw_wr)   irq_q <= sw_irq;
      else if (consume) irq_q <= 1'b0;
      if (mono)         chan_q <= 1'b0;
      else if (deliver) chan_q <= right_i;
    end
  end

  assign word_o  = buf_q;
  assign valid_o = valid_q;
  assign irq_o   = irq_q;
  assign ovf_o   = ovf_q;
  assign chan_o  = chan_q;
  assign dma_o   = dma_q;

  // R6
  rx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && valid_q && !consume) |=> (ovf_q && valid_q));
  // R4
  rx_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !deliver && !sw_wr) |=> (!irq_q && !valid_q));
  // R9
  rx_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> (irq_q && dma_q && valid_q));
  // R7
  rx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !sw_wr) |=> ovf_q);
endmodule

// File: rtl/aud_xfer_buf.sv
`timescale 1ns/1ps
module aud_xfer_buf
  import aud_xfer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cfg_ulaw_exp,
  input  logic              cfg_ulaw_cmp,
  input  logic              cfg_tx_mono,
  input  logic              cfg_rx_mono,
  input  logic              tx_ien,
  input  logic              rx_ien,
  input  logic              glb_ien,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [WORD_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_right,
  output logic              irq,
  output logic              dma_tx,
  output logic              dma_rx
);
  logic wr_lo, wr_hi, wr_st, rd_hi;
  logic tx_narrow, rx_narrow;
  logic tx_irq_f, tx_unf_f, tx_ch_f;
  logic rx_irq_f, rx_ovf_f, rx_ch_f, rx_full;
  logic [WORD_W-1:0] rx_word;

  assign wr_lo     = bus_wr && (bus_addr == A_LO);
  assign wr_hi     = bus_wr && (bus_addr == A_HI);
  assign wr_st     = bus_wr && (bus_addr == A_STAT);
  assign rd_hi     = bus_rd && (bus_addr == A_HI);
  assign tx_narrow = !cfg_wide || cfg_ulaw_exp;
  assign rx_narrow = !cfg_wide || cfg_ulaw_cmp;

  aud_xfer_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .lo_wr(wr_lo), .hi_wr(wr_hi), .wdata(bus_wdata),
    .narrow(tx_narrow), .mono(cfg_tx_mono), .fetch(tx_ready), .sw_wr(wr_st),
    .sw_irq(bus_wdata[ST_TXIRQ]), .sw_unf(bus_wdata[ST_TXUNF]),
    .word_o(tx_data), .valid_o(tx_valid), .irq_o(tx_irq_f), .unf_o(tx_unf_f),
    .chan_o(tx_ch_f), .dma_o(dma_tx)
  );

  aud_xfer_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .deliver(rx_valid), .word_i(rx_data),
    .right_i(rx_right), .consume(rd_hi), .mono(cfg_rx_mono), .sw_wr(wr_st),
    .sw_irq(bus_wdata[ST_RXIRQ]), .sw_ovf(bus_wdata[ST_RXOVF]),
    .word_o(rx_word), .valid_o(rx_full), .irq_o(rx_irq_f), .ovf_o(rx_ovf_f),
    .chan_o(rx_ch_f), .dma_o(dma_rx)
  );

  assign rx_ready = !rx_full;
  assign irq = glb_ien && ((tx_ien && tx_irq_f) || (rx_ien && rx_irq_f));

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_LO:   bus_rdata = rx_word[BYTE_W-1:0];
      A_HI:   bus_rdata = rx_narrow ? rx_word[BYTE_W-1:0] : rx_word[WORD_W-1:BYTE_W];
      A_STAT: begin
        bus_rdata[ST_TXIRQ] = tx_irq_f;
        bus_rdata[ST_RXIRQ] = rx_irq_f;
        bus_rdata[ST_TXUNF] = tx_unf_f;
        bus_rdata[ST_RXOVF] = rx_ovf_f;
        bus_rdata[ST_TXCH]  = tx_ch_f;
        bus_rdata[ST_RXCH]  = rx_ch_f;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (glb_ien && (tx_ien || rx_ien)));
  // R4
  rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rx_valid) |=> rx_ready);
endmodule

// File: tb/aud_xfer_buf_test.sv
`timescale 1ns/1ps
module aud_xfer_buf_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wide = 1'b1, cfg_ulaw_exp = 1'b0, cfg_ulaw_cmp = 1'b0;
  logic cfg_tx_mono = 1'b0, cfg_rx_mono = 1'b0;
  logic tx_ien = 1'b0, rx_ien = 1'b0, glb_ien = 1'b0;
  logic [1:0] bus_addr = 2'd3;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic tx_ready = 1'b0, tx_valid;
  logic [15:0] tx_data;
  logic rx_valid = 1'b0, rx_ready, rx_right = 1'b0;
  logic [15:0] rx_data = 16'h0000;
  logic irq, dma_tx, dma_rx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  aud_xfer_buf uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [7:0]  m_lo;
  logic [15:0] m_txbuf, m_rxbuf;
  bit m_txv, m_txirq, m_unf, m_txch, m_dtx;
  bit m_rxv, m_rxirq, m_ovf, m_rxch, m_drx;

  always @(posedge clk) begin
    bit wl, wh, ws, rh, fetch, del;
    bit o_txv, o_rxv;
    if (!rst_n) begin
      m_lo = 0; m_txbuf = 0; m_rxbuf = 0;
      m_txv = 0; m_txirq = 0; m_unf = 0; m_txch = 0; m_dtx = 0;
      m_rxv = 0; m_rxirq = 0; m_ovf = 0; m_rxch = 0; m_drx = 0;
    end else begin
      wl = bus_wr && bus_addr == 0;
      wh = bus_wr && bus_addr == 1;
      ws = bus_wr && bus_addr == 2;
      rh = bus_rd && bus_addr == 1;
      fetch = tx_ready;
      del = rx_valid;
      o_txv = m_txv;
      o_rxv = m_rxv;
      m_dtx = fetch;
      m_drx = del;
      if (wh) m_txbuf = (!cfg_wide || cfg_ulaw_exp) ? {8'h00, bus_wdata} : {bus_wdata, m_lo};
      if (wl) m_lo = bus_wdata;
      m_txv = wh ? 1'b1 : (fetch ? 1'b0 : o_txv);
      if (fetch && !o_txv) m_unf = 1; else if (ws) m_unf = bus_wdata[2];
      if (fetch) m_txirq = 1; else if (ws) m_txirq = bus_wdata[0]; else if (wh) m_txirq = 0;
      if (cfg_tx_mono) m_txch = 0; else if (wh) m_txch = !m_txch;
      if (del) m_rxbuf = rx_data;
      m_rxv = del ? 1'b1 : (rh ? 1'b0 : o_rxv);
      if (del && o_rxv && !rh) m_ovf = 1; else if (ws) m_ovf = bus_wdata[3];
      if (del) m_rxirq = 1; else if (ws) m_rxirq = bus_wdata[1]; else if (rh) m_rxirq = 0;
      if (cfg_rx_mono) m_rxch = 0; else if (del) m_rxch = rx_right;
    end
  end

  always @(posedge clk) begin
    logic [7:0] exp_rd;
    #5;
    if (rst_n && !done) begin
      case (bus_addr)
        2'd0: exp_rd = m_rxbuf[7:0];
        2'd1: exp_rd = (!cfg_wide || cfg_ulaw_cmp) ? m_rxbuf[7:0] : m_rxbuf[15:8];
        2'd2: exp_rd = {2'b00, m_rxch, m_txch, m_ovf, m_unf, m_rxirq, m_txirq};
        default: exp_rd = 8'h00;
      endcase
      chk("R2 tx_valid model", {31'd0, tx_valid}, {31'd0, m_txv});
      chk("R5 tx_data model", {16'd0, tx_data}, {16'd0, m_txbuf});
      chk("R4 rx_ready model", {31'd0, rx_ready}, {31'd0, !m_rxv});
      chk("R8 irq model", {31'd0, irq},
          {31'd0, glb_ien && ((tx_ien && m_txirq) || (rx_ien && m_rxirq))});
      chk("R9 dma_tx model", {31'd0, dma_tx}, {31'd0, m_dtx});
      chk("R9 dma_rx model", {31'd0, dma_rx}, {31'd0, m_drx});
      chk("R11 rdata model", {24'd0, bus_rdata}, {24'd0, exp_rd});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_addr = 2'd3;
  endtask

  task automatic fetch();
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic deliver(input logic [15:0] w, input logic r);
    @(negedge clk); rx_valid = 1; rx_data = w; rx_right = r;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_valid", {31'd0, tx_valid}, 0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 1);
    chk("R1 irq/dma", {29'd0, irq, dma_tx, dma_rx}, 0);
    chk("R1 tx_data", {16'd0, tx_data}, 0);
    rd(2, d); chk("R1 status", {24'd0, d}, 0);

    // R2 wide TX commit
    wr(0, 8'h34); wr(1, 8'h12);
    chk("R2 tx_data", {16'd0, tx_data}, 32'h1234);
    chk("R2 tx_valid", {31'd0, tx_valid}, 1);
    rd(2, d); chk("R10 tx_chan toggles", {24'd0, d}, 32'h10);

    // R9 fetch event with all enables off
    fetch();
    chk("R9 dma_tx pulse", {31'd0, dma_tx}, 1);
    chk("R9 tx_valid cleared", {31'd0, tx_valid}, 0);
    rd(2, d); chk("R9 tx_irq set", {24'd0, d}, 32'h11);
    chk("R9 dma_tx one cycle", {31'd0, dma_tx}, 0);

    // R5 underflow resends stale word
    fetch();
    chk("R5 stale tx_data", {16'd0, tx_data}, 32'h1234);
    rd(2, d); chk("R5 underflow flag", {24'd0, d}, 32'h15);

    // R2 low byte kept; R9 tx_irq cleared by high write; R7 sticky
    wr(1, 8'h99);
    chk("R2 kept low byte", {16'd0, tx_data}, 32'h9934);
    rd(2, d); chk("R7 unf sticky", {24'd0, d}, 32'h04);
    wr(2, 8'h00);
    rd(2, d); chk("R7 cleared by write", {24'd0, d}, 0);

    // R3 narrow TX
    cfg_wide = 0;
    wr(1, 8'h56); chk("R3 8-bit word", {16'd0, tx_data}, 32'h0056);
    cfg_wide = 1; cfg_ulaw_exp = 1;
    wr(1, 8'h77); chk("R3 ulaw word", {16'd0, tx_data}, 32'h0077);
    cfg_ulaw_exp = 0;

    // R8 interrupt gating on a software-set flag
    wr(2, 8'h01);
    #1 chk("R8 glb off", {31'd0, irq}, 0);
    glb_ien = 1; #1 chk("R8 tx_ien off", {31'd0, irq}, 0);
    tx_ien = 1; #1 chk("R8 sw-set raises", {31'd0, irq}, 1);
    wr(2, 8'h00); chk("R8 cleared", {31'd0, irq}, 0);

    // R4 wide RX read; R10 rx channel
    rx_ien = 1;
    deliver(16'hABCD, 1);
    chk("R4 rx_ready low", {31'd0, rx_ready}, 0);
    chk("R9 dma_rx pulse", {31'd0, dma_rx}, 1);
    chk("R8 rx irq", {31'd0, irq}, 1);
    rd(2, d); chk("R10 rx_chan right", {24'd0, d}, 32'h22);
    rd(0, d); chk("R4 low byte", {24'd0, d}, 32'hCD);
    rd(1, d); chk("R4 high byte", {24'd0, d}, 32'hAB);
    chk("R4 buffer freed", {31'd0, rx_ready}, 1);
    rd(2, d); chk("R4 rx_irq cleared", {24'd0, d}, 32'h20);

    // R6 overflow
    deliver(16'h1111, 0);
    deliver(16'h2222, 1);
    rd(2, d); chk("R6 overflow flag", {24'd0, d}, 32'h2A);
    rd(0, d); chk("R6 overwritten low", {24'd0, d}, 32'h22);
    rd(1, d); chk("R6 overwritten high", {24'd0, d}, 32'h22);
    rd(2, d); chk("R7 ovf sticky", {24'd0, d}, 32'h28);
    wr(2, 8'h00);

    // R4 narrow RX
    cfg_wide = 0;
    deliver(16'h00C3, 0);
    rd(1, d); chk("R4 8-bit read", {24'd0, d}, 32'hC3);
    cfg_wide = 1; cfg_ulaw_cmp = 1;
    deliver(16'h005A, 0);
    rd(1, d); chk("R4 ulaw read", {24'd0, d}, 32'h5A);
    cfg_ulaw_cmp = 0;

    // R10 mono
    cfg_tx_mono = 1; cfg_rx_mono = 1;
    wr(0, 8'h01); wr(1, 8'h02);
    deliver(16'h4444, 1);
    rd(2, d); chk("R10 mono channel bits", {24'd0, d}, 32'h02);
    rd(3, d); chk("R11 address 3", {24'd0, d}, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule